// File: doc/BRIEF.md
# Hash Engine Control and Status Register Block

This block is the register front end of a hash accelerator. A host reaches it through simple 32-bit word writes and reads at a byte offset. It holds the source address, destination address, key buffer address and source length of the next job. Each value is trimmed by a per-register mask as it is written. A crypt command word is also stored, unmasked, and read back.

A write to the hash command register is decoded at once. A two-level algorithm code is checked against a fixed list of accepted pairs: a family in bits [6:4] and a sub-variant in bits [12:10]. If the pair is accepted, the block sends a one-cycle start pulse to the datapath. The pulse carries an algorithm index, the scatter-gather flag and the accumulate flag. If the pair is not accepted, nothing is started.

When the datapath reports completion, a status bit is set. The interrupt line is raised only if the last started command asked for it. Software clears both by writing 1 to the status bit.

Top module: `hashcfg_regs`

## Requirements
- R1: After reset, every register reads as zero and `irq_o` and `start_o` are low.
- R2: Register offsets are as follows:
  - crypt command 0x10 (stored unmasked);
  - status 0x1C;
  - source address 0x20, keeps the low 31 bits;
  - destination address 0x24, keeps the low 31 bits with bits [2:0] cleared;
  - key buffer 0x28, keeps the low 31 bits with bits [2:0] cleared;
  - source length 0x2C, keeps the low 28 bits;
  - hash command 0x30.
- R3: The hash command register stores the written word ANDed with the command mask (default 0x0014_7FFF). Decoding uses the masked word.
- R4: An accepted command yields these algorithm indices (0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256, 4 SHA-512, 5 SHA-384), given as {bits[6:4], bits[12:10]}:
  - 000/000 gives 0;
  - 010/000 gives 1;
  - 100/000 gives 2;
  - 101/000 gives 3;
  - 110/000 gives 4;
  - 110/001 gives 5;
  - 110/010 gives 3;
  - 110/011 gives 2.
- R5: Any other {bits[6:4], bits[12:10]} pair starts no operation.
- R6: An accepted command write produces `start_o` high for exactly one cycle, in the cycle after the write.
  - `start_sg_o` is command bit 18.
  - `start_acc_o` is 1 exactly when bits [8:7] equal 2'b10.
- R7: A `done_i` pulse sets status bit 9 whether or not the interrupt was enabled.
- R8: On `done_i`, `irq_o` rises only if the last accepted command had bit 9 set. The command itself does not raise `irq_o`.
- R9: Writing status with bit 9 = 1 clears status bit 9 and lowers `irq_o`. Writing it with bit 9 = 0 leaves both unchanged.
- R10: A read of any other offset, including a misaligned one, returns zero. A write there changes no register.
- R11: `rdata` is updated one cycle after a read request and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request for this cycle |
| rd_en | input | 1 | Read request for this cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| done_i | input | 1 | Completion pulse from the hash datapath |
| start_o | output | 1 | One-cycle start pulse |
| start_algo_o | output | 3 | Decoded algorithm index |
| start_sg_o | output | 1 | Scatter-gather flag of the started command |
| start_acc_o | output | 1 | Accumulate flag of the started command |
| irq_o | output | 1 | Interrupt line |

## Verification
A wrong mask or a wrong offset decode shows on the first read-back of the affected register, one cycle after the read request. A wrong algorithm decode shows on the cycle after the command write: either the start pulse carries the wrong index, or a pulse appears for a rejected pair, or no pulse appears for an accepted one. A stale interrupt-enable latch or a broken clear path in the status logic shows on `irq_o` in the cycle after `done_i` or after the status write. The bench checks every one of these windows at the ports.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int NREG = 7;

  // register slots
  localparam int IDX_CRYPT = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_SRC   = 2;
  localparam int IDX_DST   = 3;
  localparam int IDX_KEY   = 4;
  localparam int IDX_LEN   = 5;
  localparam int IDX_CMD   = 6;

  localparam logic [7:0] REG_OFF [NREG] = '{8'h10, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30};

  // command and status bit positions
  localparam int DONE_BIT  = 9;
  localparam int IRQEN_BIT = 9;
  localparam int SG_BIT    = 18;
  localparam int MODE_LO   = 7;
  localparam int FAM_LO    = 4;
  localparam int VAR_LO    = 10;
  localparam logic [1:0] MODE_ACCUM = 2'b10;

  typedef enum logic [2:0] {
    ALG_MD5    = 3'd0,
    ALG_SHA1   = 3'd1,
    ALG_SHA224 = 3'd2,
    ALG_SHA256 = 3'd3,
    ALG_SHA512 = 3'd4,
    ALG_SHA384 = 3'd5
  } algo_e;
endpackage

// File: rtl/hcr_addr_decode.sv
module hcr_addr_decode
  import hcr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   sel,
  output logic              hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    assign sel[i] = (addr == ADDR_W'(REG_OFF[i]));
  end

  assign hit = |sel;

  always_comb begin
    a_onehot_r10: assert ($onehot0(sel));
  end
endmodule

// File: rtl/hcr_algo_decode.sv
module hcr_algo_decode
  import hcr_pkg::*;
(
  input  logic [2:0] fam,
  input  logic [2:0] sub,
  output logic       valid,
  output algo_e      algo
);
  always_comb begin
    valid = 1'b1;
    algo  = ALG_MD5;
    unique case ({fam, sub})
      6'b000_000: algo = ALG_MD5;
      6'b010_000: algo = ALG_SHA1;
      6'b100_000: algo = ALG_SHA224;
      6'b101_000: algo = ALG_SHA256;
      6'b110_000: algo = ALG_SHA512;
      6'b110_001: algo = ALG_SHA384;
      6'b110_010: algo = ALG_SHA256;
      6'b110_011: algo = ALG_SHA224;
      default: begin
        valid = 1'b0;
        algo  = ALG_MD5;
      end
    endcase
  end
endmodule

// File: rtl/hcr_status_irq.sv
module hcr_status_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic clr_i,
  input  logic arm_i,
  input  logic arm_val_i,
  output logic status_o,
  output logic irq_o
);
  logic stat_q, stat_d;
  logic irq_q, irq_d;
  logic en_q, en_d;

  always_comb begin
    stat_d = stat_q;
    irq_d  = irq_q;
    en_d   = en_q;
    if (arm_i) en_d = arm_val_i;
    if (clr_i) begin
      stat_d = 1'b0;
      if (stat_q) irq_d = 1'b0;
    end
    if (done_i) begin
      stat_d = 1'b1;
      if (en_q) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
      en_q   <= en_d;
    end
  end

  assign status_o = stat_q;
  assign irq_o    = irq_q;

  p_done_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> status_o);
  p_irq_needs_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> status_o);
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !irq_o) |=> !irq_o);
  p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !done_i) |=> (!status_o && !irq_o));
endmodule

// File: rtl/hashcfg_regs.sv
module hashcfg_regs
  import hcr_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          ADDR_BITS  = 31,
  parameter int          KEY_ALIGN  = 3,
  parameter int          LEN_BITS   = 28,
  parameter logic [31:0] CMD_MASK   = 32'h0014_7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              done_i,
  output logic              start_o,
  output logic [2:0]        start_algo_o,
  output logic              start_sg_o,
  output logic              start_acc_o,
  output logic              irq_o
);
  localparam logic [32:0] ONE33    = 33'd1;
  localparam logic [31:0] ADDR_MSK = 32'((ONE33 << ADDR_BITS) - ONE33);
  localparam logic [31:0] DST_MSK  = ADDR_MSK & ~32'h7;
  localparam logic [31:0] KEY_MSK  = ADDR_MSK & ~32'((ONE33 << KEY_ALIGN) - ONE33);
  localparam logic [31:0] LEN_MSK  = 32'((ONE33 << LEN_BITS) - ONE33);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // offset decode
  logic [NREG-1:0] sel;
  logic            hit;
  logic [NREG-1:0] wr_sel;
  hcr_addr_decode #(.ADDR_W(ADDR_W)) u_adec (.addr(addr), .sel(sel), .hit(hit));
  assign wr_sel = sel & {NREG{wr_en}};

  // command decode on the masked word
  logic [31:0] cmd_w;
  logic        alg_valid;
  algo_e       alg_idx;
  assign cmd_w = wdata & CMD_MASK;
  hcr_algo_decode u_alg (
    .fam  (cmd_w[FAM_LO+2:FAM_LO]),
    .sub  (cmd_w[VAR_LO+2:VAR_LO]),
    .valid(alg_valid),
    .algo (alg_idx)
  );

  logic cmd_go;
  assign cmd_go = wr_sel[IDX_CMD] & alg_valid;

  // storage registers
  logic [31:0] src_q, dst_q, key_q, len_q, cmd_q, crypt_q;
  logic [31:0] src_d, dst_d, key_d, len_d, cmd_d, crypt_d;

  always_comb begin
    src_d   = src_q;
    dst_d   = dst_q;
    key_d   = key_q;
    len_d   = len_q;
    cmd_d   = cmd_q;
    crypt_d = crypt_q;
    if (wr_sel[IDX_SRC])   src_d   = wdata & ADDR_MSK;
    if (wr_sel[IDX_DST])   dst_d   = wdata & DST_MSK;
    if (wr_sel[IDX_KEY])   key_d   = wdata & KEY_MSK;
    if (wr_sel[IDX_LEN])   len_d   = wdata & LEN_MSK;
    if (wr_sel[IDX_CMD])   cmd_d   = cmd_w;
    if (wr_sel[IDX_CRYPT]) crypt_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      src_q   <= '0;
      dst_q   <= '0;
      key_q   <= '0;
      len_q   <= '0;
      cmd_q   <= '0;
      crypt_q <= '0;
    end else begin
      src_q   <= src_d;
      dst_q   <= dst_d;
      key_q   <= key_d;
      len_q   <= len_d;
      cmd_q   <= cmd_d;
      crypt_q <= crypt_d;
    end
  end

  // start pulse and its payload
  logic       start_q, start_d;
  logic [2:0] salg_q, salg_d;
  logic       ssg_q, ssg_d, sacc_q, sacc_d;

  always_comb begin
    start_d = cmd_go;
    salg_d  = salg_q;
    ssg_d   = ssg_q;
    sacc_d  = sacc_q;
    if (cmd_go) begin
      salg_d = alg_idx;
      ssg_d  = cmd_w[SG_BIT];
      sacc_d = (cmd_w[MODE_LO+1:MODE_LO] == MODE_ACCUM);
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      start_q <= 1'b0;
      salg_q  <= 3'd0;
      ssg_q   <= 1'b0;
      sacc_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      salg_q  <= salg_d;
      ssg_q   <= ssg_d;
      sacc_q  <= sacc_d;
    end
  end

  assign start_o      = start_q;
  assign start_algo_o = salg_q;
  assign start_sg_o   = ssg_q;
  assign start_acc_o  = sacc_q;

  // completion status and interrupt
  logic stat_bit;
  hcr_status_irq u_stat (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .done_i   (done_i),
    .clr_i    (wr_sel[IDX_STAT] & wdata[DONE_BIT]),
    .arm_i    (cmd_go),
    .arm_val_i(cmd_w[IRQEN_BIT]),
    .status_o (stat_bit),
    .irq_o    (irq_o)
  );

  // read path
  logic [31:0] view [NREG];
  logic [31:0] rd_mux;
  logic [31:0] rdata_q, rdata_d;

  always_comb begin
    view[IDX_CRYPT] = crypt_q;
    view[IDX_STAT]  = 32'(stat_bit) << DONE_BIT;
    view[IDX_SRC]   = src_q;
    view[IDX_DST]   = dst_q;
    view[IDX_KEY]   = key_q;
    view[IDX_LEN]   = len_q;
    view[IDX_CMD]   = cmd_q;
    rd_mux = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel[i]) rd_mux = rd_mux | view[i];
    end
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end
  assign rdata = rdata_q;

  p_start_from_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    start_o |-> $past(wr_en && sel[IDX_CMD]));
  p_invalid_no_start_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_sel[IDX_CMD] && !alg_valid) |=> !start_o);
  p_algo_range_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    start_o |-> (start_algo_o <= 3'd5));
  p_cmd_masked_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_q & ~CMD_MASK) == 32'd0);
  p_ignore_outside_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && !hit) |=> ($stable(src_q) && $stable(cmd_q) && $stable(len_q)));
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/tb_hashcfg_regs.sv
`timescale 1ns/1ps
module tb_hashcfg_regs;
  logic        clk, rst_n, wr_en, rd_en, done_i;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        start_o, start_sg_o, start_acc_o, irq_o;
  logic [2:0]  start_algo_o;

  hashcfg_regs dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done_i(done_i), .start_o(start_o),
    .start_algo_o(start_algo_o), .start_sg_o(start_sg_o),
    .start_acc_o(start_acc_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] rd_q[$];
  string       rd_tag[$];
  logic [4:0]  st_q[$];
  string       st_tag[$];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_cmd(logic [31:0] d, bit ok, logic [2:0] alg, bit sg, bit acc, string tag);
    if (ok) begin
      st_q.push_back({alg, sg, acc});
      st_tag.push_back(tag);
    end
    wr(8'h30, d);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    rd_q.push_back(exp);
    rd_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
  endtask

  // monitor: compares design results against queued expectations
  always @(negedge clk) begin
    if (rd_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = rd_q.pop_front();
      t = rd_tag.pop_front();
      chk(rdata == e, t, rdata, e);
    end
    if (start_o) begin
      if (st_q.size() == 0) begin
        chk(1'b0, "R5 unexpected start", {27'd0, start_algo_o, start_sg_o, start_acc_o}, 32'd0);
      end else begin
        logic [4:0] e5;
        string t5;
        e5 = st_q.pop_front();
        t5 = st_tag.pop_front();
        chk({start_algo_o, start_sg_o, start_acc_o} == e5, t5,
            {27'd0, start_algo_o, start_sg_o, start_acc_o}, {27'd0, e5});
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [31:0] hold;

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; done_i = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(irq_o == 1'b0, "R1 irq after reset", {31'd0, irq_o}, 32'd0);
    chk(start_o == 1'b0, "R1 start after reset", {31'd0, start_o}, 32'd0);
    rd(8'h10, 32'd0, "R1 crypt reset");
    rd(8'h1C, 32'd0, "R1 status reset");
    rd(8'h20, 32'd0, "R1 src reset");
    rd(8'h24, 32'd0, "R1 dst reset");
    rd(8'h28, 32'd0, "R1 key reset");
    rd(8'h2C, 32'd0, "R1 len reset");
    rd(8'h30, 32'd0, "R1 cmd reset");

    // R2 masks
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, 32'h7FFF_FFFF, "R2 src mask");
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, 32'h7FFF_FFF8, "R2 dst mask");
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, 32'h7FFF_FFF8, "R2 key mask");
    wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C, 32'h0FFF_FFFF, "R2 len mask");
    wr(8'h2C, 32'h1234_5678); rd(8'h2C, 32'h0234_5678, "R2 len pattern");
    wr(8'h10, 32'hDEAD_BEEF); rd(8'h10, 32'hDEAD_BEEF, "R2 crypt stored");

    // R3 command mask; family 111 invalid, so no start (R5)
    wr_cmd(32'hFFFF_FFFF, 0, 3'd0, 0, 0, "R5");
    rd(8'h30, 32'h0014_7FFF, "R3 cmd mask");
    // bits outside the mask do not disturb decode (bit 31, bit 15)
    wr_cmd(32'h8000_8020, 1, 3'd1, 0, 0, "R3 masked decode sha1");
    rd(8'h30, 32'h0000_0020, "R3 cmd stored masked");

    // R4 / R6 decode table
    wr_cmd(32'h0000_0000, 1, 3'd0, 0, 0, "R4 md5");
    wr_cmd(32'h0000_0020, 1, 3'd1, 0, 0, "R4 sha1");
    wr_cmd(32'h0000_0040, 1, 3'd2, 0, 0, "R4 sha224");
    wr_cmd(32'h0000_0050, 1, 3'd3, 0, 0, "R4 sha256");
    wr_cmd(32'h0000_0060, 1, 3'd4, 0, 0, "R4 sha512");
    wr_cmd(32'h0000_0460, 1, 3'd5, 0, 0, "R4 sha384");
    wr_cmd(32'h0000_0860, 1, 3'd3, 0, 0, "R4 family sha256");
    wr_cmd(32'h0000_0C60, 1, 3'd2, 0, 0, "R4 family sha224");

    // R6 flags
    wr_cmd(32'h0004_0050, 1, 3'd3, 1, 0, "R6 sg flag");
    wr_cmd(32'h0000_0150, 1, 3'd3, 0, 1, "R6 accumulate flag");
    wr_cmd(32'h0000_01D0, 1, 3'd3, 0, 0, "R6 hmac key not accumulate");
    wr_cmd(32'h0000_00D0, 1, 3'd3, 0, 0, "R6 hmac not accumulate");

    // R5 invalid pairs
    wr_cmd(32'h0000_0030, 0, 3'd0, 0, 0, "R5");
    wr_cmd(32'h0000_0070, 0, 3'd0, 0, 0, "R5");
    wr_cmd(32'h0000_0470, 0, 3'd0, 0, 0, "R5");
    wr_cmd(32'h0000_1060, 0, 3'd0, 0, 0, "R5");
    wr_cmd(32'h0000_0420, 0, 3'd0, 0, 0, "R5");
    repeat (2) @(negedge clk);
    chk(st_q.size() == 0, "R6 all starts seen", st_q.size(), 32'd0);

    // R10 outside window
    wr(8'h14, 32'h1234_5678);
    rd(8'h14, 32'd0, "R10 unmapped read");
    rd(8'h20, 32'h7FFF_FFFF, "R10 src untouched by unmapped write");
    wr(8'h21, 32'h0000_0001);
    rd(8'h20, 32'h7FFF_FFFF, "R10 src untouched by misaligned write");
    rd(8'h21, 32'd0, "R10 misaligned read");

    // R11 hold
    rd(8'h2C, 32'h0234_5678, "R11 read");
    repeat (2) @(negedge clk);
    hold = rdata;
    chk(hold == 32'h0234_5678, "R11 rdata holds", hold, 32'h0234_5678);

    // R7 done with interrupt disabled
    wr_cmd(32'h0000_0020, 1, 3'd1, 0, 0, "R7 start no irq");
    pulse_done();
    chk(irq_o == 1'b0, "R8 no irq when disabled", {31'd0, irq_o}, 32'd0);
    rd(8'h1C, 32'h0000_0200, "R7 status set without irq enable");

    // R9 write 0 keeps, write 1 clears
    wr(8'h1C, 32'h0000_0000);
    rd(8'h1C, 32'h0000_0200, "R9 write zero keeps status");
    wr(8'h1C, 32'h0000_0200);
    rd(8'h1C, 32'h0000_0000, "R9 write one clears status");

    // R8 done with interrupt enabled
    wr_cmd(32'h0000_0220, 1, 3'd1, 0, 0, "R8 start with irq");
    chk(irq_o == 1'b0, "R8 irq waits for done", {31'd0, irq_o}, 32'd0);
    pulse_done();
    chk(irq_o == 1'b1, "R8 irq on done", {31'd0, irq_o}, 32'd1);
    rd(8'h1C, 32'h0000_0200, "R7 status with irq");
    wr(8'h1C, 32'h0000_0000);
    chk(irq_o == 1'b1, "R9 write zero keeps irq", {31'd0, irq_o}, 32'd1);
    wr(8'h1C, 32'h0000_0200);
    chk(irq_o == 1'b0, "R9 clear lowers irq", {31'd0, irq_o}, 32'd0);
    rd(8'h1C, 32'h0000_0000, "R9 status cleared");

    // R8 rejected command keeps the previous enable (enabled)
    wr_cmd(32'h0000_0030, 0, 3'd0, 0, 0, "R5");
    pulse_done();
    chk(irq_o == 1'b1, "R8 enable from last accepted command", {31'd0, irq_o}, 32'd1);
    wr(8'h1C, 32'h0000_0200);
    chk(irq_o == 1'b0, "R9 clear again", {31'd0, irq_o}, 32'd0);

    repeat (3) @(negedge clk);
    chk(st_q.size() == 0, "R6 no pending start", st_q.size(), 32'd0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule